// File: doc/BRIEF.md
# Display interrupt pending controller

This block keeps the two interrupt pending flags of a display processor: one for the vertical (frame) interrupt and one for the horizontal (line) interrupt. The vertical flag is set from the horizontal slot position on the first inactive line. The slot that sets it depends on the selected video mode. The horizontal flag is set by a strobe from an external line counter. The block drives a level interrupt request toward the CPU whenever a pending flag has its enable set.

When the CPU acknowledges, the block does not learn which interrupt the CPU began to service. It clears whichever enabled flag is asserted at that moment, and vertical is chosen first. A flag can therefore be cleared even though a different interrupt caused the exception. The acknowledge only works in the full mode. In the compatibility mode it is ignored.

Top module: `disp_irq_ctrl`

## Requirements
- R1: While `rst_n` is low, both pending flags are cleared, and `irq_req` and `irq_vsel` are low.
- R2: With `mode5`=1, a cycle with `slot_tick`=1, `first_blank_line`=1 and `slot_cnt`=255 sets `vpend` at the next clock edge. The same cycle with any other slot value does not set it.
- R3: With `mode5`=0, the vertical flag is set at slot 4 instead (same conditions as R2). With `mode5`=0, slot 255 does not set it.
- R4: The vertical flag is not set when `first_blank_line`=0 or `slot_tick`=0, whatever the slot value.
- R5: A cycle with `hline_evt`=1 sets `hpend` at the next edge. Both flags are set whatever the state of the enables.
- R6: `irq_req` is 1 exactly when (`vpend` and `vint_en`) or (`hpend` and `hint_en`). `irq_vsel` is 1 exactly when `vpend` and `vint_en` are both 1, which gives vertical priority.
- R7: An `ack` in full mode while `vpend`=1 and `vint_en`=1 clears only `vpend`. `hpend` is kept.
- R8: An `ack` in full mode while vertical is not both pending and enabled, but `hpend`=1 and `hint_en`=1, clears `hpend`. A pending but disabled `vpend` is kept.
- R9: An `ack` in full mode while no flag is both pending and enabled changes neither flag.
- R10: An `ack` with `mode5`=0 changes neither flag.
- R11: If a set event and an `ack` that would clear the same flag arrive in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_tick | input | 1 | Marks the cycle where `slot_cnt` holds a new slot |
| slot_cnt | input | SLOT_W | Current horizontal slot number |
| first_blank_line | input | 1 | High during the first inactive line of the frame |
| hline_evt | input | 1 | Horizontal interrupt event from the line counter |
| vint_en | input | 1 | Vertical interrupt enable |
| hint_en | input | 1 | Horizontal interrupt enable |
| mode5 | input | 1 | 1 = full mode, 0 = compatibility mode |
| ack | input | 1 | One-cycle CPU interrupt acknowledge |
| vpend | output | 1 | Vertical pending flag |
| hpend | output | 1 | Horizontal pending flag |
| irq_req | output | 1 | Interrupt request level |
| irq_vsel | output | 1 | High when the active request is the vertical one |

## Verification
The bench acknowledges with both flags pending. A design that cleared both flags, or that cleared the horizontal one first, would lose a pending line interrupt. It also acknowledges with a vertical flag that is pending but disabled: a design that ignored the enables would clear the wrong flag. It applies the slot of the other mode, which would raise the frame interrupt at the wrong point in the line. Finally it acknowledges in compatibility mode and collides an acknowledge with a set event; a design that let the clear win would drop an interrupt that has just arrived.

// File: rtl/disp_irq_ctrl.sv
module disp_irq_ctrl #(
  parameter int SLOT_W       = 8,
  parameter int VSLOT_FULL   = 255,
  parameter int VSLOT_COMPAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_tick,
  input  logic [SLOT_W-1:0] slot_cnt,
  input  logic              first_blank_line,
  input  logic              hline_evt,
  input  logic              vint_en,
  input  logic              hint_en,
  input  logic              mode5,
  input  logic              ack,
  output logic              vpend,
  output logic              hpend,
  output logic              irq_req,
  output logic              irq_vsel
);
  localparam logic [SLOT_W-1:0] VS_FULL   = SLOT_W'(VSLOT_FULL);
  localparam logic [SLOT_W-1:0] VS_COMPAT = SLOT_W'(VSLOT_COMPAT);

  logic [SLOT_W-1:0] v_slot;
  logic v_set, v_live, h_live, v_clr, h_clr;

  assign v_slot = mode5 ? VS_FULL : VS_COMPAT;
  assign v_set  = slot_tick && first_blank_line && (slot_cnt == v_slot);
  assign v_live = vpend && vint_en;
  assign h_live = hpend && hint_en;
  assign v_clr  = ack && mode5 && v_live;
  assign h_clr  = ack && mode5 && !v_live && h_live;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vpend <= 1'b0;
      hpend <= 1'b0;
    end else begin
      vpend <= v_set || (vpend && !v_clr);
      hpend <= hline_evt || (hpend && !h_clr);
    end
  end

  assign irq_req  = v_live || h_live;
  assign irq_vsel = v_live;
endmodule

module disp_irq_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic first_blank_line,
  input logic hline_evt,
  input logic vint_en,
  input logic hint_en,
  input logic mode5,
  input logic ack,
  input logic vpend,
  input logic hpend,
  input logic irq_req,
  input logic irq_vsel
);
  p_ack_v_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && mode5 && vpend && vint_en && !first_blank_line) |=> !vpend);
  p_ack_v_keeps_h_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && mode5 && vpend && vint_en && hpend) |=> hpend);
  p_ack_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !mode5) |=> (vpend || !$past(vpend)) && (hpend || !$past(hpend)));
  p_hset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hline_evt |=> hpend);
  p_req_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (vpend || hpend));
  p_vsel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_vsel |-> irq_req);
  p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!first_blank_line && !hline_evt && !ack) |=> ($stable(vpend) && $stable(hpend)));
endmodule

bind disp_irq_ctrl disp_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .first_blank_line(first_blank_line),
  .hline_evt(hline_evt), .vint_en(vint_en), .hint_en(hint_en),
  .mode5(mode5), .ack(ack), .vpend(vpend), .hpend(hpend),
  .irq_req(irq_req), .irq_vsel(irq_vsel)
);

// File: tb/disp_irq_ctrl_tb.sv
module disp_irq_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slot_tick = 0, first_blank_line = 0, hline_evt = 0;
  logic vint_en = 0, hint_en = 0, mode5 = 1, ack = 0;
  logic [7:0] slot_cnt = 0;
  logic vpend, hpend, irq_req, irq_vsel;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  disp_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .slot_cnt(slot_cnt),
    .first_blank_line(first_blank_line), .hline_evt(hline_evt),
    .vint_en(vint_en), .hint_en(hint_en), .mode5(mode5), .ack(ack),
    .vpend(vpend), .hpend(hpend), .irq_req(irq_req), .irq_vsel(irq_vsel)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
    slot_tick = 0; first_blank_line = 0; hline_evt = 0; ack = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; step(); step(); rst_n = 1;
  endtask

  task automatic vslot(bit m5, int s, bit fbl);
    mode5 = m5; slot_tick = 1; slot_cnt = 8'(s); first_blank_line = fbl; step();
  endtask

  task automatic t_reset_r1();
    hline_evt = 1; step(); vslot(1, 255, 1);
    vint_en = 1; hint_en = 1; rst_n = 0; step();
    chk("R1 vpend", vpend, 0); chk("R1 hpend", hpend, 0);
    chk("R1 irq_req", irq_req, 0); chk("R1 irq_vsel", irq_vsel, 0);
    rst_n = 1; vint_en = 0; hint_en = 0;
  endtask

  task automatic t_vset_full_r2();
    do_reset();
    vslot(1, 254, 1); chk("R2 slot254", vpend, 0);
    vslot(1, 4, 1);   chk("R2 slot4 full", vpend, 0);
    vslot(1, 255, 1); chk("R2 slot255", vpend, 1);
    chk("R6 disabled no req", irq_req, 0);
  endtask

  task automatic t_vset_compat_r3();
    do_reset();
    vslot(0, 255, 1); chk("R3 slot255 compat", vpend, 0);
    vslot(0, 4, 1);   chk("R3 slot4 compat", vpend, 1);
  endtask

  task automatic t_gate_r4();
    do_reset();
    vslot(1, 255, 0); chk("R4 not first blank", vpend, 0);
    mode5 = 1; slot_cnt = 255; first_blank_line = 1; slot_tick = 0; step();
    chk("R4 no tick", vpend, 0);
  endtask

  task automatic t_hset_r5_r6();
    do_reset();
    hline_evt = 1; step(); chk("R5 hpend", hpend, 1);
    chk("R6 req h disabled", irq_req, 0);
    hint_en = 1; #1; chk("R6 req h", irq_req, 1); chk("R6 vsel h", irq_vsel, 0);
    vslot(1, 255, 1); vint_en = 1; #1;
    chk("R6 req both", irq_req, 1); chk("R6 vsel both", irq_vsel, 1);
  endtask

  task automatic t_ack_both_r7();
    do_reset(); vint_en = 1; hint_en = 1;
    hline_evt = 1; step(); vslot(1, 255, 1);
    mode5 = 1; ack = 1; step();
    chk("R7 vpend cleared", vpend, 0); chk("R7 hpend kept", hpend, 1);
    ack = 1; step();
    chk("R8 hpend cleared", hpend, 0); chk("R6 req idle", irq_req, 0);
  endtask

  task automatic t_ack_vdis_r8();
    do_reset(); vint_en = 0; hint_en = 1;
    hline_evt = 1; step(); vslot(1, 255, 1);
    ack = 1; step();
    chk("R8 vpend kept", vpend, 1); chk("R8 hpend cleared", hpend, 0);
  endtask

  task automatic t_ack_none_r9();
    do_reset(); vint_en = 0; hint_en = 0;
    hline_evt = 1; step(); vslot(1, 255, 1);
    ack = 1; step();
    chk("R9 vpend kept", vpend, 1); chk("R9 hpend kept", hpend, 1);
  endtask

  task automatic t_ack_compat_r10();
    do_reset(); vint_en = 1; hint_en = 1;
    hline_evt = 1; step(); vslot(0, 4, 1);
    mode5 = 0; ack = 1; step();
    chk("R10 vpend kept", vpend, 1); chk("R10 hpend kept", hpend, 1);
    ack = 1; step();
    chk("R10 vpend kept again", vpend, 1);
    mode5 = 1;
  endtask

  task automatic t_collide_r11();
    do_reset(); vint_en = 1; hint_en = 1;
    vslot(1, 255, 1);
    mode5 = 1; slot_tick = 1; slot_cnt = 255; first_blank_line = 1; ack = 1; step();
    chk("R11 vertical set wins", vpend, 1);
    do_reset(); hint_en = 1; vint_en = 0;
    hline_evt = 1; step();
    hline_evt = 1; ack = 1; step();
    chk("R11 horizontal set wins", hpend, 1);
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #5;
    t_reset_r1();
    t_vset_full_r2();
    t_vset_compat_r3();
    t_gate_r4();
    t_hset_r5_r6();
    t_ack_both_r7();
    t_ack_vdis_r8();
    t_ack_none_r9();
    t_ack_compat_r10();
    t_collide_r11();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule